// File: doc/BRIEF.md
# Parallel Expander Product-Term Chain

This block is the sum-of-products stage for banks of programmable logic cells. Each cell owns a fixed number of already evaluated product-term bits. Cells are arranged in groups. A cell can borrow whole term sets from the cells just below it in the same group and add them to its own OR. A static configuration gives, for each cell, how many neighbour sets it borrows. The block returns one OR result per cell. It also returns the number of borrowed sets that each cell actually received, so that timing can charge one delay increment per set.

Borrowing runs in one direction only, upward. A cell that borrows depth `d` takes the sets of the `d` cells directly below it. A set that is lent leaves the lender's own OR completely. A request is rejected as a whole, flagged, and treated as depth zero if any of these holds:
- it reaches below the bottom of its group;
- it is made by the bottom cell of a group, which can only lend;
- it asks for a set already taken by a lower-numbered borrower.

The top cell of a group is never lent from, because no cell above it in the same group can borrow.

A registered copy of the per-cell set counts is also provided, with a synchronous active-low reset.

Top module: `pexp_chain`

## Requirements
- R1: A cell with borrow depth 0 whose set is not lent drives its OR output high exactly when any of its own five term bits is high. Cell k's terms are `pterm[k*5 +: 5]`.
- R2: A cell whose request for depth d (1 to 3) is accepted ORs in the five terms of each of cells k-1 down to k-d. Cell k's depth field is `borrow_cfg[k*2 +: 2]`, read as an unsigned count.
- R3: A cell whose set is taken by an accepted borrower no longer sees its own terms in its own OR output.
- R4: `sets_used[k*2 +: 2]` equals the accepted depth of cell k, and equals 0 for a rejected or zero request.
- R5: A nonzero request from the bottom cell of a group (cells 0 and 8) is ignored and raises `cfg_err[k]`.
- R6: A request whose depth exceeds the cell's position within its group would cross the group boundary. It is ignored as a whole and raises `cfg_err[k]`.
- R7: When two requests want the same lender, the lower-numbered borrower keeps it. The higher-numbered request is ignored as a whole and raises its `cfg_err` bit. A cell may borrow and lend in the same configuration.
- R8: `sets_used_q` is cleared while `rst_n` is low at a rising edge. Otherwise it holds the `sets_used` value from the previous rising edge.
- R9: At depth 3, each of the twenty term bits that feed one cell (five own, fifteen borrowed) alone drives that cell's output high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered set counts |
| rst_n | input | 1 | Synchronous active-low reset |
| pterm | input | 80 | Evaluated product-term bits, five per cell |
| borrow_cfg | input | 32 | Requested borrow depth, two bits per cell |
| or_out | output | 16 | Per-cell OR result |
| sets_used | output | 32 | Accepted borrow depth per cell, two bits each |
| cfg_err | output | 16 | Per-cell flag for a rejected request |
| sets_used_q | output | 32 | Registered copy of `sets_used` |

## Verification
The bench builds the block with its defaults: two groups of eight cells, five terms per cell and at most three sets. With these values both group boundaries and both bottom cells (0 and 8) can be reached, and cells 3 to 7 and 11 to 15 can take the full twenty-term depth. Directed cases cover single-term sweeps, lend removal, conflicts between nearby borrowers and cross-boundary requests. Sparse random term patterns combined with random depth fields then mix these rules together.

// File: rtl/pexp_pkg.sv
// Shared constants and helpers for the parallel expander chain.
// Assumes depth fields are unsigned counts of borrowed neighbour sets.
package pexp_pkg;
    localparam int unsigned PEXP_GROUP_CELLS = 8;
    localparam int unsigned PEXP_NUM_GROUPS  = 2;
    localparam int unsigned PEXP_TERMS       = 5;
    localparam int unsigned PEXP_MAX_SETS    = 3;

    // True when a request of depth d from group position p stays in range.
    function automatic bit depth_fits(input int p, input int d, input int max_sets);
        return (d <= p) && (d <= max_sets);
    endfunction
endpackage

// File: rtl/pexp_claim.sv
// Borrow arbiter for one group of cells.
// Walks positions from bottom to top. A request is granted only when it
// fits inside the group and none of its lenders is already taken, so a
// lower-numbered borrower wins every conflict. A rejected request is
// dropped as a whole and flagged. Assumes static configuration inputs.
module pexp_claim
    import pexp_pkg::*;
#(
    parameter int unsigned GROUP_CELLS = 8,
    parameter int unsigned MAX_SETS    = 3,
    parameter int unsigned DW          = 2
) (
    input  logic [GROUP_CELLS*DW-1:0] req,
    output logic [GROUP_CELLS*DW-1:0] grant,
    output logic [GROUP_CELLS-1:0]    reject,
    output logic [GROUP_CELLS-1:0]    lent
);
    // Sequential claim walk: grant, reject and record taken lenders.
    always_comb begin
        logic [GROUP_CELLS-1:0] taken;
        logic [GROUP_CELLS-1:0] want;
        int d;
        taken  = '0;
        grant  = '0;
        reject = '0;
        for (int p = 0; p < int'(GROUP_CELLS); p++) begin
            d    = int'(req[p*DW +: DW]);
            want = '0;
            for (int j = 0; j < int'(GROUP_CELLS); j++) begin
                if (j < p && j + d >= p) want[j] = 1'b1;
            end
            if (d != 0) begin
                if (depth_fits(p, d, int'(MAX_SETS)) && ((want & taken) == '0)) begin
                    taken = taken | want;
                    grant[p*DW +: DW] = req[p*DW +: DW];
                end else begin
                    reject[p] = 1'b1;
                end
            end
        end
        lent = taken;
    end
endmodule

// File: rtl/pexp_cell_or.sv
// OR gate of one cell: own terms (unless lent away) plus the granted
// number of neighbour sets. Window set s holds the terms of cell k-1-s.
// Assumes the window is zero-padded below the bottom of the group.
module pexp_cell_or #(
    parameter int unsigned TERMS    = 5,
    parameter int unsigned MAX_SETS = 3,
    parameter int unsigned DW       = 2
) (
    input  logic [TERMS-1:0]          own,
    input  logic                      lent,
    input  logic [MAX_SETS*TERMS-1:0] win,
    input  logic [DW-1:0]             sets,
    output logic                      sum
);
    // Sum own terms and the first `sets` neighbour sets.
    always_comb begin
        sum = (|own) & ~lent;
        for (int s = 0; s < int'(MAX_SETS); s++) begin
            if (s < int'(sets)) sum = sum | (|win[s*TERMS +: TERMS]);
        end
    end
endmodule

// File: rtl/pexp_group.sv
// One group of cells: the borrow arbiter plus one OR gate per cell.
// Neighbour windows are cut from a zero-padded copy of the group's terms,
// so no term from outside the group can ever reach a cell.
module pexp_group #(
    parameter int unsigned GROUP_CELLS = 8,
    parameter int unsigned TERMS       = 5,
    parameter int unsigned MAX_SETS    = 3,
    parameter int unsigned DW          = 2
) (
    input  logic [GROUP_CELLS*TERMS-1:0] pt,
    input  logic [GROUP_CELLS*DW-1:0]    req,
    output logic [GROUP_CELLS-1:0]       sum,
    output logic [GROUP_CELLS*DW-1:0]    sets,
    output logic [GROUP_CELLS-1:0]       reject
);
    localparam int unsigned PAD_W = (GROUP_CELLS + MAX_SETS) * TERMS;

    logic [GROUP_CELLS-1:0] lent;
    logic [PAD_W-1:0]       pad;

    // Zero padding below position 0 stands for the group edge.
    assign pad = {pt, {(MAX_SETS*TERMS){1'b0}}};

    pexp_claim #(
        .GROUP_CELLS(GROUP_CELLS),
        .MAX_SETS   (MAX_SETS),
        .DW         (DW)
    ) u_claim (
        .req   (req),
        .grant (sets),
        .reject(reject),
        .lent  (lent)
    );

    for (genvar p = 0; p < GROUP_CELLS; p++) begin : g_cell
        logic [MAX_SETS*TERMS-1:0] win;
        for (genvar s = 0; s < MAX_SETS; s++) begin : g_win
            assign win[s*TERMS +: TERMS] = pad[(p - 1 - s + MAX_SETS)*TERMS +: TERMS];
        end
        pexp_cell_or #(
            .TERMS   (TERMS),
            .MAX_SETS(MAX_SETS),
            .DW      (DW)
        ) u_or (
            .own (pt[p*TERMS +: TERMS]),
            .lent(lent[p]),
            .win (win),
            .sets(sets[p*DW +: DW]),
            .sum (sum[p])
        );
    end
endmodule

// File: rtl/pexp_chain.sv
// Parallel expander chain over all groups of cells.
// Outputs are combinational, plus a registered copy of the per-cell set
// counts (synchronous active-low reset). Assumes borrow_cfg is static
// between changes and that groups never share terms.
module pexp_chain
    import pexp_pkg::*;
#(
    parameter int unsigned NUM_GROUPS  = PEXP_NUM_GROUPS,
    parameter int unsigned GROUP_CELLS = PEXP_GROUP_CELLS,
    parameter int unsigned TERMS       = PEXP_TERMS,
    parameter int unsigned MAX_SETS    = PEXP_MAX_SETS,
    parameter int unsigned DW          = $clog2(MAX_SETS + 1),
    parameter int unsigned CELLS       = NUM_GROUPS * GROUP_CELLS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CELLS*TERMS-1:0] pterm,
    input  logic [CELLS*DW-1:0]    borrow_cfg,
    output logic [CELLS-1:0]       or_out,
    output logic [CELLS*DW-1:0]    sets_used,
    output logic [CELLS-1:0]       cfg_err,
    output logic [CELLS*DW-1:0]    sets_used_q
);
    localparam int unsigned GT = GROUP_CELLS * TERMS;
    localparam int unsigned GD = GROUP_CELLS * DW;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        pexp_group #(
            .GROUP_CELLS(GROUP_CELLS),
            .TERMS      (TERMS),
            .MAX_SETS   (MAX_SETS),
            .DW         (DW)
        ) u_grp (
            .pt    (pterm[g*GT +: GT]),
            .req   (borrow_cfg[g*GD +: GD]),
            .sum   (or_out[g*GROUP_CELLS +: GROUP_CELLS]),
            .sets  (sets_used[g*GD +: GD]),
            .reject(cfg_err[g*GROUP_CELLS +: GROUP_CELLS])
        );
    end

    // Registered copy of the set counts for delay bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) sets_used_q <= '0;
        else        sets_used_q <= sets_used;
    end
endmodule

// File: rtl/pexp_chain_chk.sv
// Property checker for pexp_chain, attached by the bind below.
module pexp_chain_chk #(
    parameter int unsigned NUM_GROUPS  = 2,
    parameter int unsigned GROUP_CELLS = 8,
    parameter int unsigned TERMS       = 5,
    parameter int unsigned MAX_SETS    = 3,
    parameter int unsigned DW          = 2,
    parameter int unsigned CELLS       = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [CELLS*TERMS-1:0] pterm,
    input logic [CELLS*DW-1:0]    borrow_cfg,
    input logic [CELLS-1:0]       or_out,
    input logic [CELLS*DW-1:0]    sets_used,
    input logic [CELLS-1:0]       cfg_err,
    input logic [CELLS*DW-1:0]    sets_used_q
);
    // R1: no terms anywhere means every OR output is low.
    p_quiet_terms_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pterm == '0) |-> (or_out == '0));

    // R8: registered counts follow the combinational counts by one edge.
    p_reg_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sets_used_q == $past(sets_used)));

    for (genvar k = 0; k < CELLS; k++) begin : g_k
        localparam int unsigned POS = k % GROUP_CELLS;
        // R4: a flagged cell reports no borrowed sets.
        p_err_no_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_err[k] |-> (sets_used[k*DW +: DW] == '0));
        // R6: granted depth never reaches past the group bottom.
        p_in_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(sets_used[k*DW +: DW]) <= int'(POS)));
        // R2: granted depth is either the request or zero.
        p_grant_is_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sets_used[k*DW +: DW] == '0) || (sets_used[k*DW +: DW] == borrow_cfg[k*DW +: DW]));
        if (POS == 0) begin : g_low
            // R5: a bottom cell with a nonzero request is flagged.
            p_low_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (borrow_cfg[k*DW +: DW] != '0) |-> cfg_err[k]);
        end
    end
endmodule

bind pexp_chain pexp_chain_chk #(
    .NUM_GROUPS (NUM_GROUPS),
    .GROUP_CELLS(GROUP_CELLS),
    .TERMS      (TERMS),
    .MAX_SETS   (MAX_SETS),
    .DW         (DW),
    .CELLS      (CELLS)
) u_chk (.*);

// File: tb/tb_pexp_chain.sv
// Scoreboard bench: drive() computes the expected result and queues it;
// the monitor pops one item per clock and compares it with the outputs.
module tb_pexp_chain;
    localparam int G  = 8;
    localparam int NG = 2;
    localparam int T  = 5;
    localparam int MS = 3;
    localparam int DW = 2;
    localparam int N  = G * NG;

    typedef struct {
        logic [N-1:0]    o;
        logic [N*DW-1:0] s;
        logic [N-1:0]    e;
        string           tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*T-1:0]  pterm = '0;
    logic [N*DW-1:0] borrow_cfg = '0;
    logic [N-1:0]    or_out;
    logic [N*DW-1:0] sets_used;
    logic [N-1:0]    cfg_err;
    logic [N*DW-1:0] sets_used_q;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;
    exp_t q[$];

    always #5 clk = ~clk;

    pexp_chain dut (
        .clk(clk), .rst_n(rst_n), .pterm(pterm), .borrow_cfg(borrow_cfg),
        .or_out(or_out), .sets_used(sets_used), .cfg_err(cfg_err),
        .sets_used_q(sets_used_q)
    );

    // Reference model written from R1-style rules: grant walk, lend removal, OR.
    function automatic exp_t model(input logic [N*T-1:0] pt, input logic [N*DW-1:0] cf);
        exp_t r;
        bit   taken [N];
        r.o = '0; r.s = '0; r.e = '0; r.tag = "";
        for (int k = 0; k < N; k++) taken[k] = 1'b0;
        for (int k = 0; k < N; k++) begin
            int  pos = k % G;
            int  d   = int'(cf[k*DW +: DW]);
            bit  ok  = (d <= pos);
            for (int j = 1; j <= d; j++) if (ok && taken[k-j]) ok = 1'b0;
            if (d != 0 && !ok) r.e[k] = 1'b1;
            if (d != 0 && ok) begin
                r.s[k*DW +: DW] = DW'(d);
                for (int j = 1; j <= d; j++) taken[k-j] = 1'b1;
            end
        end
        for (int k = 0; k < N; k++) begin
            int d = int'(r.s[k*DW +: DW]);
            if (!taken[k] && (|pt[k*T +: T])) r.o[k] = 1'b1;
            for (int j = 1; j <= d; j++) if (|pt[(k-j)*T +: T]) r.o[k] = 1'b1;
        end
        return r;
    endfunction

    task automatic drive(input logic [N*T-1:0] pt, input logic [N*DW-1:0] cf, input string tag);
        exp_t x;
        @(negedge clk);
        pterm = pt;
        borrow_cfg = cf;
        x = model(pt, cf);
        x.tag = tag;
        q.push_back(x);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare outputs one step after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            check({x.tag, " or_out"}, 64'(or_out), 64'(x.o));
            check("R4 sets_used", 64'(sets_used), 64'(x.s));
            check({x.tag, " cfg_err"}, 64'(cfg_err), 64'(x.e));
            check("R8 sets_used_q", 64'(sets_used_q), 64'(x.s));
        end
    end

    function automatic logic [N*DW-1:0] cfg1(input int k, input int d);
        logic [N*DW-1:0] c;
        c = '0;
        c[k*DW +: DW] = DW'(d);
        return c;
    endfunction

    function automatic logic [N*T-1:0] bit1(input int i);
        logic [N*T-1:0] p;
        p = '0;
        p[i] = 1'b1;
        return p;
    endfunction

    initial begin : watchdog
        #1500000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [N*T-1:0]  pt;
        logic [N*DW-1:0] cf;
        // R8: reset clears the register even with a live request present.
        borrow_cfg = cfg1(2, 1);
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset", 64'(sets_used_q), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // R1: single own terms, no borrowing.
        for (int i = 0; i < N*T; i += 3) drive(bit1(i), '0, "R1");
        // R2/R3: cell 3 borrows two sets; a term in cell 1 moves to cell 3.
        drive(bit1(1*T + 4), cfg1(3, 2), "R2");
        drive(bit1(2*T), cfg1(3, 2), "R3");
        drive(bit1(3*T + 1), cfg1(3, 2), "R1");
        // R9: full depth at cell 7 and cell 15, sweep all twenty terms.
        for (int i = 0; i < 4*T; i++) drive(bit1(4*T + i), cfg1(7, 3), "R9");
        for (int i = 0; i < 4*T; i++) drive(bit1(12*T + i), cfg1(15, 3), "R9");
        // R5: bottom cells of both groups.
        drive(bit1(0), cfg1(0, 1), "R5");
        drive(bit1(7*T), cfg1(8, 2), "R5");
        // R6: crossing the group boundary from cells 9 and 10.
        drive(bit1(7*T + 2), cfg1(10, 3), "R6");
        drive(bit1(8*T), cfg1(9, 2), "R6");
        drive(bit1(6*T), cfg1(9, 1), "R6");
        // R7: conflict, lower borrower wins; chained borrow-and-lend allowed.
        cf = cfg1(4, 2) | cfg1(5, 3);
        drive(bit1(2*T), cf, "R7");
        cf = cfg1(4, 2) | cfg1(5, 1);
        drive(bit1(4*T), cf, "R7");
        drive(bit1(3*T), cf, "R7");
        cf = cfg1(12, 1) | cfg1(13, 1);
        drive(bit1(11*T + 3), cf, "R7");
        // Mixed random patterns over all rules.
        for (int r = 0; r < 60; r++) begin
            pt = '0;
            cf = '0;
            for (int k = 0; k < N; k++) begin
                if ($urandom_range(0, 3) == 0) pt[k*T + int'($urandom_range(0, T-1))] = 1'b1;
                if ($urandom_range(0, 2) == 0) cf[k*DW +: DW] = DW'($urandom_range(1, MS));
            end
            drive(pt, cf, "R2");
        end
        while (q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule